// File: doc/BRIEF.md
# Manual Serial Bit Command Engine

This block lets software drive a serial management link one primitive at a time. It is used for recovery work, such as resetting a slave device before the automatic link channel takes over. Each accepted command does exactly one thing. It can set chip-select high, set chip-select low, issue one clock pulse, or shift an 8-bit value out on one, two or four data lines with a clock pulse per group of bits.

A pin mux picks what reaches the link pins. When manual mode is selected, the engine drives chip-select, the serial clock and four data lines. Otherwise the pins carry the automatic channel's signals unchanged. The engine reports busy while a primitive runs and sync-idle when nothing is pending. On every rising serial clock edge it captures one input bit from the slave.

The control state machine has four states. Idle waits for a command. Chip-select-set lasts one cycle after a chip-select command. Clock-low and clock-high are the two halves of each serial clock period. The transitions are:
- Idle goes to chip-select-set on a chip-select command.
- Idle goes to clock-low on a pulse or output command.
- Clock-low goes to clock-high when the half-period timer expires.
- Clock-high goes back to clock-low when pulses remain.
- Clock-high goes to idle after the last pulse.
- Chip-select-set returns to idle on the next cycle.

Top module: `mse_engine`

## Requirements
- R1: After reset, the link pins show chip-select high, serial clock low and data lines 0. Busy is 0 and sync-idle is 1.
- R2: The opcode sits in command bits 11:8. Opcode 0 sets chip-select high and opcode 1 sets it low, from the accepting clock edge onward. Busy is then high for exactly one cycle.
- R3: Opcode 2 issues one serial clock pulse: HALF_DIV cycles low, then HALF_DIV cycles high, then low again. Busy lasts 2*HALF_DIV cycles and the data lines do not change.
- R4: Opcode 8 shifts command bits 7:0 out MSB first on data line 0, with upper lines at 0. It takes 8 pulses and each new bit appears at the start of a low phase.
- R5: Opcode 9 shifts bits 7:0 out two at a time on lines 1:0, with bits 7:6 first and upper lines at 0. It takes 4 pulses.
- R6: Opcode 10 shifts the upper nibble on lines 3:0, then the lower nibble. It takes 2 pulses.
- R7: An output opcode (8, 9, 10) is accepted only with command bit 13 set. Any opcode other than 0, 1, 2, 8, 9 or 10 is dropped. A dropped command leaves busy and all pins unchanged.
- R8: Commands are accepted only while the manual-enable input is 1 and manual mode is selected. Otherwise they are dropped.
- R9: A command presented while busy is high is dropped.
- R10: Sync-idle is 1 exactly when busy is 0.
- R11: With manual mode not selected, the pins follow the automatic channel's chip-select, clock and data inputs.
- R12: The captured input bit takes the value of the slave data input at each rising serial clock edge and holds it otherwise.
- R13: A slave reset sequence completes with busy 0 and sync-idle 1. The sequence is chip-select low, one single-line output, chip-select high, then four single-line outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| man_en | input | 1 | Manual-enable control |
| mux_manual | input | 1 | 1 selects the manual engine onto the pins |
| cmd_valid | input | 1 | Command write strobe |
| cmd | input | 16 | Command word (bit 13 write, 11:8 opcode, 7:0 data) |
| auto_cs | input | 1 | Chip-select from the automatic channel |
| auto_sclk | input | 1 | Serial clock from the automatic channel |
| auto_data | input | 4 | Data lines from the automatic channel |
| ser_di | input | 1 | Serial data input from the slave |
| spi_cs | output | 1 | Chip-select pin (1 = high) |
| spi_sclk | output | 1 | Serial clock pin |
| spi_data | output | 4 | Data line pins |
| rx_bit | output | 1 | Last captured input bit |
| busy | output | 1 | Primitive in progress |
| sync_idle | output | 1 | Engine idle with nothing pending |

## Verification
The bench builds the engine with HALF_DIV set to 2. This keeps the low and high halves of a pulse longer than one cycle, so the half-period timer's terminal count is exercised rather than skipped. Every 8-bit value is swept through single-, dual- and quad-line output. At every cycle of each transfer, the bench compares clock level, data lines and busy against positions it computes from the data value. The short periods also leave time to cover dropped commands, the pin mux, input capture and the full slave reset sequence.

// File: rtl/mse_pkg.sv
package mse_pkg;
    localparam int DATA_W = 8;
    localparam int LINES  = 4;

    localparam logic [3:0] OPC_CS_HIGH = 4'd0;
    localparam logic [3:0] OPC_CS_LOW  = 4'd1;
    localparam logic [3:0] OPC_PULSE   = 4'd2;
    localparam logic [3:0] OPC_OUT1    = 4'd8;
    localparam logic [3:0] OPC_OUT2    = 4'd9;
    localparam logic [3:0] OPC_OUT4    = 4'd10;

    localparam int BIT_WRITE = 13;

    typedef enum logic [1:0] {LANE1, LANE2, LANE4} lane_e;

    typedef enum logic [1:0] {S_IDLE, S_CSET, S_LOW, S_HIGH} state_e;
endpackage

// File: rtl/mse_decode.sv
module mse_decode
    import mse_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic [15:0]      cmd,
    input  logic             open,
    output logic             accept,
    output logic             is_cs,
    output logic             cs_level,
    output logic             is_out,
    output lane_e            lane,
    output logic [CNT_W-1:0] pulses
);
    logic [3:0] op;
    logic       is_pulse;

    always_comb begin
        op       = cmd[11:8];
        is_cs    = (op == OPC_CS_HIGH) || (op == OPC_CS_LOW);
        cs_level = (op == OPC_CS_HIGH);
        is_pulse = (op == OPC_PULSE);
        is_out   = cmd[BIT_WRITE] &&
                   ((op == OPC_OUT1) || (op == OPC_OUT2) || (op == OPC_OUT4));
        accept   = open && (is_cs || is_pulse || is_out);
        lane     = LANE1;
        pulses   = CNT_W'(1);
        if (is_out) begin
            if (op == OPC_OUT2) begin
                lane   = LANE2;
                pulses = CNT_W'(DATA_W / 2);
            end else if (op == OPC_OUT4) begin
                lane   = LANE4;
                pulses = CNT_W'(DATA_W / 4);
            end else begin
                lane   = LANE1;
                pulses = CNT_W'(DATA_W);
            end
        end
    end
endmodule

// File: rtl/mse_phase.sv
module mse_phase #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int PW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(HALF_DIV - 1);

    logic [PW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear || tick)
            cnt_q <= '0;
        else if (run)
            cnt_q <= cnt_q + 1'b1;
    end

    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/mse_shift.sv
module mse_shift
    import mse_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  lane_e             lane_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              advance,
    output logic [LINES-1:0]  lines
);
    lane_e             lane_q;
    logic [DATA_W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= LANE1;
            sr_q   <= '0;
        end else if (load) begin
            lane_q <= lane_in;
            sr_q   <= data_in;
        end else if (advance) begin
            unique case (lane_q)
                LANE1:   sr_q <= sr_q << 1;
                LANE2:   sr_q <= sr_q << 2;
                default: sr_q <= sr_q << 4;
            endcase
        end
    end

    always_comb begin
        unique case (lane_q)
            LANE1:   lines = {3'b000, sr_q[DATA_W-1]};
            LANE2:   lines = {2'b00, sr_q[DATA_W-1 -: 2]};
            default: lines = sr_q[DATA_W-1 -: 4];
        endcase
    end
endmodule

// File: rtl/mse_engine.sv
module mse_engine
    import mse_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             man_en,
    input  logic             mux_manual,
    input  logic             cmd_valid,
    input  logic [15:0]      cmd,
    input  logic             auto_cs,
    input  logic             auto_sclk,
    input  logic [LINES-1:0] auto_data,
    input  logic             ser_di,
    output logic             spi_cs,
    output logic             spi_sclk,
    output logic [LINES-1:0] spi_data,
    output logic             rx_bit,
    output logic             busy,
    output logic             sync_idle
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    state_e           state_q, state_d;
    logic             accept, is_cs, cs_level, is_out, tick, running;
    lane_e            lane;
    logic [CNT_W-1:0] pulses, left_q;
    logic             cs_q, rx_q;
    logic             m_sclk;
    logic [LINES-1:0] m_data;

    mse_decode #(.CNT_W(CNT_W)) u_dec (
        .cmd(cmd), .open(cmd_valid && man_en && mux_manual && !busy),
        .accept(accept), .is_cs(is_cs), .cs_level(cs_level),
        .is_out(is_out), .lane(lane), .pulses(pulses)
    );

    assign running = (state_q == S_LOW) || (state_q == S_HIGH);

    mse_phase #(.HALF_DIV(HALF_DIV)) u_phase (
        .clk(clk), .rst_n(rst_n), .clear(accept), .run(running), .tick(tick)
    );

    mse_shift u_shift (
        .clk(clk), .rst_n(rst_n),
        .load(accept && is_out), .lane_in(lane), .data_in(cmd[DATA_W-1:0]),
        .advance((state_q == S_HIGH) && tick && (left_q != CNT_W'(1))),
        .lines(m_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept) state_d = is_cs ? S_CSET : S_LOW;
            S_CSET: state_d = S_IDLE;
            S_LOW:  if (tick) state_d = S_HIGH;
            S_HIGH: if (tick) state_d = (left_q == CNT_W'(1)) ? S_IDLE : S_LOW;
            default: state_d = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            left_q <= '0;
            rx_q   <= 1'b0;
        end else begin
            if (accept && is_cs)
                cs_q <= cs_level;
            if (accept && !is_cs)
                left_q <= pulses;
            else if ((state_q == S_HIGH) && tick)
                left_q <= left_q - 1'b1;
            if ((state_q == S_LOW) && tick)
                rx_q <= ser_di;
        end
    end

    // Outputs
    always_comb begin
        busy      = (state_q != S_IDLE);
        sync_idle = (state_q == S_IDLE);
        m_sclk    = (state_q == S_HIGH);
        rx_bit    = rx_q;
        spi_cs    = mux_manual ? cs_q   : auto_cs;
        spi_sclk  = mux_manual ? m_sclk : auto_sclk;
        spi_data  = mux_manual ? m_data : auto_data;
    end

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    p_cs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(cs_q));
    p_data_steady_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HIGH) && !tick |=> $stable(m_data));
    p_sclk_rise_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_sclk) |-> busy);
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= CNT_W'(DATA_W));
    p_idle_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({busy, sync_idle}));
endmodule

// File: tb/mse_engine_test.sv
module mse_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int H = 2;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        man_en = 0, mux_manual = 0, cmd_valid = 0;
    logic [15:0] cmd = '0;
    logic        auto_cs = 0, auto_sclk = 0;
    logic [3:0]  auto_data = '0;
    logic        ser_di = 0;
    logic        spi_cs, spi_sclk, rx_bit, busy, sync_idle;
    logic [3:0]  spi_data;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mse_engine #(.HALF_DIV(H)) uut (
        .clk(clk), .rst_n(rst_n), .man_en(man_en), .mux_manual(mux_manual),
        .cmd_valid(cmd_valid), .cmd(cmd), .auto_cs(auto_cs),
        .auto_sclk(auto_sclk), .auto_data(auto_data), .ser_di(ser_di),
        .spi_cs(spi_cs), .spi_sclk(spi_sclk), .spi_data(spi_data),
        .rx_bit(rx_bit), .busy(busy), .sync_idle(sync_idle)
    );

    function automatic logic [15:0] mk(input logic wr, input logic [3:0] op,
                                       input logic [7:0] d);
        return {2'b00, wr, 1'b0, op, d};
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Leaves the bench at the first negedge after the accepting edge.
    task automatic issue(input logic [15:0] c);
        @(negedge clk);
        cmd = c;
        cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    // w = 1, 2 or 4 lines; follows a full transfer cycle by cycle
    task automatic run_out(input string req, input int w, input logic [7:0] d);
        int n = 8 / w;
        int bad = 0;
        logic [31:0] a = 0, e = 0;
        issue(mk(1'b1, (w == 1) ? 4'd8 : (w == 2) ? 4'd9 : 4'd10, d));
        for (int idx = 0; idx < n * 2 * H; idx++) begin
            int j = idx / (2 * H);
            logic ph = ((idx % (2 * H)) >= H);
            logic [3:0] chunk = 4'((int'(d) >> (8 - (j + 1) * w)) & ((1 << w) - 1));
            if (idx > 0) @(negedge clk);
            if (bad == 0 && ({spi_sclk, spi_data, busy} !== {ph, chunk, 1'b1})) begin
                bad = 1;
                a = {spi_sclk, spi_data, busy};
                e = {ph, chunk, 1'b1};
            end
        end
        @(negedge clk);
        if (bad == 0 && ({busy, sync_idle, spi_sclk} !== 3'b010)) begin
            bad = 1;
            a = {busy, sync_idle, spi_sclk};
            e = 3'b010;
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s data=%h actual=%h expected=%h", req, d, a, e);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1", {spi_cs, spi_sclk, spi_data, busy, sync_idle}, {1'b0, 1'b0, 4'h0, 1'b0, 1'b1});
        mux_manual = 1;
        man_en = 1;
        @(negedge clk);
        check("R1", {spi_cs, spi_sclk, spi_data, busy, sync_idle}, {1'b1, 1'b0, 4'h0, 1'b0, 1'b1});

        // R2 chip-select low / high
        issue(mk(1'b0, 4'd1, 8'h00));
        check("R2", {spi_cs, busy}, 2'b01);
        @(negedge clk);
        check("R2", {spi_cs, busy, sync_idle}, 3'b001);
        issue(mk(1'b0, 4'd0, 8'h00));
        check("R2", {spi_cs, busy}, 2'b11);
        @(negedge clk);
        check("R2", busy, 1'b0);

        // R4 R5 R6 exhaustive data sweeps
        for (int v = 0; v < 256; v++) run_out("R4", 1, 8'(v));
        for (int v = 0; v < 256; v++) run_out("R5", 2, 8'(v));
        for (int v = 0; v < 256; v++) run_out("R6", 4, 8'(v));

        // R3 clock pulse, data lines unchanged (last quad nibble of 0xFF is F)
        issue(mk(1'b0, 4'd2, 8'h00));
        for (int idx = 0; idx < 2 * H; idx++) begin
            if (idx > 0) @(negedge clk);
            check("R3", {spi_sclk, spi_data, busy}, {(idx >= H), 4'hF, 1'b1});
        end
        @(negedge clk);
        check("R3", {spi_sclk, busy}, 2'b00);

        // R12 input capture
        ser_di = 1;
        issue(mk(1'b0, 4'd2, 8'h00));
        repeat (2 * H) @(negedge clk);
        check("R12", rx_bit, 1'b1);
        ser_di = 0;
        repeat (3) @(negedge clk);
        check("R12", rx_bit, 1'b1);
        issue(mk(1'b0, 4'd2, 8'h00));
        repeat (2 * H) @(negedge clk);
        check("R12", rx_bit, 1'b0);

        // R7 output without write bit, and an undefined opcode
        issue(mk(1'b0, 4'd8, 8'h00));
        check("R7", {busy, spi_data}, {1'b0, 4'hF});
        issue(mk(1'b1, 4'd3, 8'h00));
        check("R7", {busy, spi_cs}, 2'b01);

        // R8 manual enable off, then mux to automatic channel
        man_en = 0;
        issue(mk(1'b0, 4'd1, 8'h00));
        check("R8", {busy, spi_cs}, 2'b01);
        man_en = 1;
        mux_manual = 0;
        auto_cs = 0; auto_sclk = 1; auto_data = 4'hA;
        issue(mk(1'b0, 4'd1, 8'h00));
        check("R11", {spi_cs, spi_sclk, spi_data}, {1'b0, 1'b1, 4'hA});
        check("R8", busy, 1'b0);
        auto_cs = 1; auto_sclk = 0; auto_data = 4'h5;
        @(negedge clk);
        check("R11", {spi_cs, spi_sclk, spi_data}, {1'b1, 1'b0, 4'h5});
        mux_manual = 1;
        @(negedge clk);
        check("R8", spi_cs, 1'b1);

        // R9 command while busy is dropped
        issue(mk(1'b0, 4'd1, 8'h00));
        @(negedge clk);
        issue(mk(1'b1, 4'd8, 8'h3C));
        issue(mk(1'b0, 4'd0, 8'h00));
        repeat (40) @(negedge clk);
        check("R9", {spi_cs, busy}, 2'b00);

        // R10 sync-idle against busy during a pulse
        issue(mk(1'b0, 4'd2, 8'h00));
        check("R10", {busy, sync_idle}, 2'b10);
        repeat (2 * H) @(negedge clk);
        check("R10", {busy, sync_idle}, 2'b01);

        // R13 slave reset sequence
        issue(mk(1'b0, 4'd1, 8'h00));
        @(negedge clk);
        run_out("R13", 1, 8'h00);
        issue(mk(1'b0, 4'd0, 8'h00));
        @(negedge clk);
        for (int k = 0; k < 4; k++) run_out("R13", 1, 8'h00);
        check("R13", {busy, sync_idle, spi_cs}, 3'b011);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule